// File: doc/BRIEF.md
# Smart Card Character Transmitter with Error and Transmit-End Flags

This block sends one eight-bit character at a time on the single, shared I/O line of a smart card in the asynchronous character format: one low start bit, eight data bits sent least significant bit first, and one even parity bit. The line is open-drain. The block only pulls it low (`io_drive_low`) and reads it back through `io_sense`. After the parity bit the block lets go of the line and looks at it once, halfway through the first guard bit. A low level seen at that moment means the card has signalled a parity error. That event latches an error flag.

Software or a DMA agent loads the data register. A status port exposes three flags: data-register-empty, transmit-end and error-signal. The transmit-end flag tells software that the line is quiet and a character has finished without complaint. How long after the parity bit it sets depends on two mode inputs: a guard-mode bit (`mode_gm`) and a block-mode bit (`mode_blk`). All timing comes from a half-etu divider whose period, in clock cycles, is set on `half_etu_cycles`. A value of 0 is treated as 1.

The controller is a state machine with six states. IDLE leads to START on *load*, when transmission is enabled and the data register is full. START leads to DATA after one etu (*start done*). DATA stays in DATA through eight bit periods and then goes to PARITY (*last data bit done*). PARITY leads to GUARD after one etu (*parity done*). GUARD leads to SETTLE at the half-etu sample point (*sample*). SETTLE leads back to IDLE when the mode-dependent settle count runs out (*settle done*). From any state, the *abort* transition returns to IDLE when transmit enable is low or the low-power hold input is high.

Top module: `sc_char_tx`

## Requirements
- R1: After reset the status reads empty=1 (bit 0), end=1 (bit 1) and error=0 (bit 2), and the line is released (`io_drive_low`=0).
- R2: A character drives the following sequence, each bit lasting two half-etu periods (2 × `half_etu_cycles` clocks): a low start bit, then data bits 0 to 7 (low for a 0), then a parity bit that makes the count of ones over data and parity even. The line is released from the end of the parity bit onward.
- R3: A character starts only when transmit enable is 1 and the empty flag is 0. It starts on the clock edge after that condition is first seen. Starting sets the empty flag to 1. With the empty flag at 1, or transmit enable at 0, the line is never driven.
- R4: The error flag sets when the synchronised line reads low one half-etu after the end of the parity bit.
- R5: The error flag clears only on a status write whose bit 2 is 0, issued after a status read that returned bit 2 as 1. A write without such a read leaves the flag at 1, and so does a write with bit 2 at 1.
- R6: Dropping transmit enable leaves the error flag unchanged.
- R7: With the empty flag at 1 and the error flag at 0 at the end of a character, the end flag sets this many half-etu periods after the end of the parity bit: 5 for gm=0/blk=0, 3 for gm=0/blk=1, and 2 for gm=1 with either blk. It is 0 one clock earlier.
- R8: When the error flag is 1, a finished character does not set the end flag.
- R9: The end flag is 1 whenever transmit enable is 0 and the error flag is 0. This takes effect one clock later and overrides clear events.
- R10: The end flag and the empty flag clear together in two cases. The first is a status write with bit 0 at 0, issued after a read that returned bit 0 as 1. The second is a data write flagged as coming from the DMA agent.
- R11: A cycle with low-power hold high sets empty and end, clears error, and returns the line to released.
- R12: `tx_req` equals the empty flag ANDed with transmit enable.
- R13: Dropping transmit enable in the middle of a character releases the line on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_hold | input | 1 | Low-power hold; resets the flags and aborts any character |
| tx_en | input | 1 | Transmit enable |
| mode_gm | input | 1 | Guard mode: shortest settle time |
| mode_blk | input | 1 | Block mode: shortened settle time |
| half_etu_cycles | input | HALF_W | Clock cycles per half etu |
| dat_wr | input | 1 | Data register write strobe |
| dat_wr_dma | input | 1 | Marks the write as coming from the DMA agent |
| dat_wdata | input | DATA_W | Data register write value |
| sts_rd | input | 1 | Status read strobe (arms the write-zero clear) |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 3 | Status write value: bit 0 empty, bit 2 error; bit 1 ignored |
| sts_flags | output | 3 | Status: bit 0 empty, bit 1 end, bit 2 error |
| tx_req | output | 1 | Transmit-data request to the DMA agent |
| io_drive_low | output | 1 | Pulls the card I/O line low |
| io_sense | input | 1 | Level of the card I/O line |

## Verification
All timing is counted from the first clock edge at which the line goes low, call it E0, with L half-etu cycles. Each bit is sampled L cycles into its period: the start bit after E0+L, data bit i after E0+(3+2i)L, and parity after E0+19L. The error flag is read just after E0+21L. Any injected low is raised after E0+20L and dropped at E0+21L, which lets it cross the two-stage synchroniser before the sample edge. The end flag is checked both one clock before and exactly at E0+(20+D)L, where D is 5, 3 or 2 by mode. Flag effects of status writes, DMA writes, hold and enable changes are checked one clock after the strobe. The one exception is the level rule for the end flag after an error clear, which needs one more clock.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

    // Controller states
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_GUARD,
        S_SETTLE
    } tx_state_e;

    // Status bit positions (software decodes these)
    localparam int unsigned ST_EMPTY = 0;
    localparam int unsigned ST_END   = 1;
    localparam int unsigned ST_ERR   = 2;
    localparam int unsigned ST_W     = 3;

    // Half-etu periods from end of parity to the end flag
    function automatic logic [2:0] settle_halves(input logic gm, input logic blk);
        if (gm)
            return 3'd2;
        else if (blk)
            return 3'd3;
        else
            return 3'd5;
    endfunction

endpackage

// File: rtl/sc_tx_halftick.sv
module sc_tx_halftick #(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] half_len,
    output logic          tick
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_c;

    assign last_c = (half_len == '0) ? '0 : half_len - CW'(1);
    assign tick   = (cnt_q == last_c);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    // A tick is one cycle wide unless the period is a single clock
    p_tick_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && last_c != '0) |=> !tick);

endmodule

// File: rtl/sc_tx_sync.sv
module sc_tx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/sc_tx_frame.sv
module sc_tx_frame
    import sc_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              lp_hold,
    input  logic              empty_flag,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_gm,
    input  logic              mode_blk,
    input  logic              half_tick,
    input  logic              sense_sync,
    output logic              restart,
    output logic              line_low,
    output logic              load,
    output logic              err_seen,
    output logic              done,
    output logic              busy
);
    localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] tdr_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_q;
    logic [BW-1:0]     bit_q;
    logic [2:0]        hcnt_q;
    logic [2:0]        settle_last;
    logic              span_end;

    assign settle_last = settle_halves(mode_gm, mode_blk) - 3'd1;
    assign span_end    = half_tick && hcnt_q[0];

    // Next state and transition strobes
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        err_seen = 1'b0;
        done     = 1'b0;
        if (!tx_en || lp_hold) begin
            state_d = S_IDLE;                        // abort
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (!empty_flag) begin
                        state_d = S_START;           // load
                        load    = 1'b1;
                    end
                end
                S_START: begin
                    if (span_end) state_d = S_DATA;  // start done
                end
                S_DATA: begin
                    if (span_end && bit_q == LAST_BIT)
                        state_d = S_PARITY;          // last data bit done
                end
                S_PARITY: begin
                    if (span_end) state_d = S_GUARD; // parity done
                end
                S_GUARD: begin
                    if (half_tick) begin
                        state_d  = S_SETTLE;         // sample
                        err_seen = !sense_sync;
                    end
                end
                S_SETTLE: begin
                    if (half_tick && hcnt_q == settle_last) begin
                        state_d = S_IDLE;            // settle done
                        done    = 1'b1;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Data register, shifter and half-etu counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdr_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
            bit_q   <= '0;
            hcnt_q  <= '0;
        end else begin
            if (wr_en) tdr_q <= wr_data;
            if (load) begin
                shift_q <= tdr_q;
                par_q   <= ^tdr_q;
                bit_q   <= '0;
                hcnt_q  <= '0;
            end else if (state_d != state_q) begin
                hcnt_q <= (state_d == S_SETTLE) ? 3'd1 : 3'd0;
            end else if (half_tick) begin
                if (state_q == S_DATA && hcnt_q[0]) begin
                    hcnt_q  <= '0;
                    shift_q <= shift_q >> 1;
                    bit_q   <= bit_q + BW'(1);
                end else begin
                    hcnt_q <= hcnt_q + 3'd1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        line_low = 1'b0;
        unique case (state_q)
            S_START:  line_low = 1'b1;
            S_DATA:   line_low = !shift_q[0];
            S_PARITY: line_low = !par_q;
            default:  line_low = 1'b0;
        endcase
    end

    assign busy    = (state_q != S_IDLE);
    assign restart = load;

    p_load_sets_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && state_d == S_START) |=> empty_flag);

    p_abort_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (state_q == S_IDLE));

endmodule

// File: rtl/sc_tx_flags.sv
module sc_tx_flags
    import sc_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lp_hold,
    input  logic            tx_en,
    input  logic            load,
    input  logic            err_seen,
    input  logic            done,
    input  logic            dat_wr,
    input  logic            dat_wr_dma,
    input  logic            sts_rd,
    input  logic            sts_wr,
    input  logic [ST_W-1:0] sts_wdata,
    output logic            empty_q,
    output logic            end_q,
    output logic            err_q
);
    logic arm_empty_q, arm_err_q;
    logic clr_empty_sw, clr_err_sw, empty_clr;
    logic unused_end_bit;

    assign unused_end_bit = sts_wdata[ST_END];
    assign clr_empty_sw   = sts_wr && arm_empty_q && !sts_wdata[ST_EMPTY];
    assign clr_err_sw     = sts_wr && arm_err_q && !sts_wdata[ST_ERR];
    assign empty_clr      = clr_empty_sw || (dat_wr && dat_wr_dma);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q     <= 1'b1;
            end_q       <= 1'b1;
            err_q       <= 1'b0;
            arm_empty_q <= 1'b0;
            arm_err_q   <= 1'b0;
        end else if (lp_hold) begin
            empty_q     <= 1'b1;
            end_q       <= 1'b1;
            err_q       <= 1'b0;
            arm_empty_q <= 1'b0;
            arm_err_q   <= 1'b0;
        end else begin
            if (err_seen)        err_q <= 1'b1;
            else if (clr_err_sw) err_q <= 1'b0;

            if (load)           empty_q <= 1'b1;
            else if (empty_clr) empty_q <= 1'b0;

            if (!tx_en && !err_q)                end_q <= 1'b1;
            else if (empty_clr)                  end_q <= 1'b0;
            else if (done && empty_q && !err_q)  end_q <= 1'b1;

            if (sts_wr) begin
                arm_empty_q <= 1'b0;
                arm_err_q   <= 1'b0;
            end else if (sts_rd) begin
                arm_empty_q <= empty_q;
                arm_err_q   <= err_q;
            end else begin
                arm_empty_q <= arm_empty_q && empty_q;
                arm_err_q   <= arm_err_q && err_q;
            end
        end
    end

    p_end_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !err_q) |=> end_q);

    p_err_clear_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_q) |-> ($past(lp_hold) || $past(clr_err_sw)));

    p_err_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !lp_hold && !clr_err_sw) |=> err_q);

    p_end_needs_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_q) |-> !err_q);

endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
    import sc_tx_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned HALF_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_hold,
    input  logic              tx_en,
    input  logic              mode_gm,
    input  logic              mode_blk,
    input  logic [HALF_W-1:0] half_etu_cycles,
    input  logic              dat_wr,
    input  logic              dat_wr_dma,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              sts_rd,
    input  logic              sts_wr,
    input  logic [ST_W-1:0]   sts_wdata,
    output logic [ST_W-1:0]   sts_flags,
    output logic              tx_req,
    output logic              io_drive_low,
    input  logic              io_sense
);
    logic half_tick, restart, sense_sync;
    logic load, err_seen, done, busy;
    logic empty_q, end_q, err_q;
    logic unused_busy;

    sc_tx_halftick #(.CW(HALF_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .half_len (half_etu_cycles),
        .tick     (half_tick)
    );

    sc_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (io_sense),
        .q     (sense_sync)
    );

    sc_tx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .lp_hold    (lp_hold),
        .empty_flag (empty_q),
        .wr_en      (dat_wr),
        .wr_data    (dat_wdata),
        .mode_gm    (mode_gm),
        .mode_blk   (mode_blk),
        .half_tick  (half_tick),
        .sense_sync (sense_sync),
        .restart    (restart),
        .line_low   (io_drive_low),
        .load       (load),
        .err_seen   (err_seen),
        .done       (done),
        .busy       (busy)
    );

    sc_tx_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_hold    (lp_hold),
        .tx_en      (tx_en),
        .load       (load),
        .err_seen   (err_seen),
        .done       (done),
        .dat_wr     (dat_wr),
        .dat_wr_dma (dat_wr_dma),
        .sts_rd     (sts_rd),
        .sts_wr     (sts_wr),
        .sts_wdata  (sts_wdata),
        .empty_q    (empty_q),
        .end_q      (end_q),
        .err_q      (err_q)
    );

    assign unused_busy         = busy;
    assign sts_flags[ST_EMPTY] = empty_q;
    assign sts_flags[ST_END]   = end_q;
    assign sts_flags[ST_ERR]   = err_q;
    assign tx_req              = empty_q && tx_en;

    // Error detection only happens while a character is in flight
    p_err_in_flight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_seen) |-> busy);

endmodule

// File: tb/test_sc_char_tx.sv
module test_sc_char_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_hold = 1'b0, tx_en = 1'b0, mode_gm = 1'b0, mode_blk = 1'b0;
    logic [11:0] half_len = 12'd4;
    logic       dat_wr = 1'b0, dat_wr_dma = 1'b0;
    logic [7:0] dat_wdata = 8'h00;
    logic       sts_rd = 1'b0, sts_wr = 1'b0;
    logic [2:0] sts_wdata = 3'b111;
    logic [2:0] sts_flags;
    logic       tx_req, io_drive_low, io_sense;
    logic       card_pull = 1'b0;
    int         n_tests = 0, n_fail = 0;
    bit         finished = 1'b0;

    assign io_sense = !(io_drive_low || card_pull);

    always #4ns clk = ~clk;

    sc_char_tx i_sc_char_tx (
        .clk(clk), .rst_n(rst_n), .lp_hold(lp_hold), .tx_en(tx_en),
        .mode_gm(mode_gm), .mode_blk(mode_blk), .half_etu_cycles(half_len),
        .dat_wr(dat_wr), .dat_wr_dma(dat_wr_dma), .dat_wdata(dat_wdata),
        .sts_rd(sts_rd), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .sts_flags(sts_flags), .tx_req(tx_req), .io_drive_low(io_drive_low),
        .io_sense(io_sense)
    );

    function automatic int exp_settle(input logic gm, input logic blk);
        return gm ? 2 : (blk ? 3 : 5);
    endfunction

    function automatic logic exp_par(input logic [7:0] d);
        return ^d;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_data(input logic [7:0] d, input logic dma);
        dat_wr = 1'b1; dat_wr_dma = dma; dat_wdata = d;
        step(1);
        dat_wr = 1'b0; dat_wr_dma = 1'b0;
    endtask

    task automatic sts_read();
        sts_rd = 1'b1; step(1); sts_rd = 1'b0;
    endtask

    task automatic sts_write(input logic [2:0] w);
        sts_wr = 1'b1; sts_wdata = w; step(1); sts_wr = 1'b0; sts_wdata = 3'b111;
    endtask

    task automatic quiet_window(input string tag, input int n);
        int lows = 0;
        for (int k = 0; k < n; k++) begin
            step(1);
            if (io_drive_low) lows++;
        end
        chk(tag, lows, 0);
    endtask

    // recover: 0 software clear, 1 software clear with enable dropped, 2 hold
    task automatic send_char(input logic [7:0] d, input logic gm, input logic blk,
                             input int lim, input bit inject, input bit via_dma,
                             input int recover);
        int waited = 0;
        int dh;
        mode_gm = gm; mode_blk = blk; half_len = 12'(lim);
        dh = exp_settle(gm, blk);
        if (via_dma) begin
            put_data(d, 1'b1);
        end else begin
            put_data(d, 1'b0);
            sts_read();
            sts_write(3'b100);
        end
        chk("R10 empty cleared", sts_flags[0], 0);
        chk("R10 end cleared", sts_flags[1], 0);
        while (!io_drive_low && waited < 8) begin step(1); waited++; end
        chk("R3 start one clock after clear", waited, 1);
        chk("R3 load sets empty", sts_flags[0], 1);
        step(lim);
        chk("R2 start bit", io_drive_low, 1);
        for (int i = 0; i < 8; i++) begin
            step(2 * lim);
            chk($sformatf("R2 data bit %0d", i), io_drive_low, !d[i]);
        end
        step(2 * lim);
        chk("R2 parity bit", io_drive_low, !exp_par(d));
        step(lim);
        chk("R2 released in guard", io_drive_low, 0);
        if (inject) card_pull = 1'b1;
        step(lim);
        card_pull = 1'b0;
        chk("R4 error flag", sts_flags[2], int'(inject));
        chk("R7 end not yet", sts_flags[1], 0);
        step((dh - 1) * lim - 1);
        chk("R7 end one clock early", sts_flags[1], 0);
        step(1);
        if (inject) chk("R8 end held low by error", sts_flags[1], 0);
        else        chk("R7 end at settle point", sts_flags[1], 1);
        chk("R12 request", tx_req, 1);
        if (inject) begin
            sts_write(3'b001);
            chk("R5 write without read", sts_flags[2], 1);
            if (recover == 2) begin
                lp_hold = 1'b1; step(1); lp_hold = 1'b0;
                chk("R11 hold flags", int'(sts_flags), 3);
            end else begin
                if (recover == 1) begin
                    tx_en = 1'b0;
                    step(3);
                    chk("R6 error kept", sts_flags[2], 1);
                    chk("R9 end stays low with error", sts_flags[1], 0);
                    chk("R12 no request when disabled", tx_req, 0);
                end
                sts_read();
                sts_write(3'b101);
                chk("R5 writing one keeps error", sts_flags[2], 1);
                sts_read();
                sts_write(3'b001);
                chk("R5 read then write zero", sts_flags[2], 0);
                if (recover == 1) begin
                    step(1);
                    chk("R9 end after error cleared", sts_flags[1], 1);
                    tx_en = 1'b1;
                end
            end
        end
    endtask

    initial begin
        #1200us;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        step(4);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset flags", int'(sts_flags), 3);
        chk("R1 line released", io_drive_low, 0);
        chk("R12 request off", tx_req, 0);

        // Disabled: DMA write clears empty but end stays by level rule
        put_data(8'h5A, 1'b1);
        chk("R10 DMA clears empty", sts_flags[0], 0);
        chk("R9 end forced while disabled", sts_flags[1], 1);
        quiet_window("R3 no start while disabled", 20);
        lp_hold = 1'b1; step(1); lp_hold = 1'b0;
        chk("R11 hold restores flags", int'(sts_flags), 3);

        tx_en = 1'b1;
        step(1);
        chk("R12 request on", tx_req, 1);
        quiet_window("R3 no start while empty", 30);

        // Directed: each mode, extreme data, each recovery path
        send_char(8'h00, 1'b0, 1'b0, 4, 1'b0, 1'b0, 0);
        send_char(8'hFF, 1'b0, 1'b1, 5, 1'b0, 1'b1, 0);
        send_char(8'h01, 1'b1, 1'b0, 4, 1'b0, 1'b0, 0);
        send_char(8'h80, 1'b1, 1'b1, 6, 1'b0, 1'b1, 0);
        send_char(8'hA5, 1'b0, 1'b0, 4, 1'b1, 1'b0, 1);
        send_char(8'h3C, 1'b1, 1'b0, 5, 1'b1, 1'b1, 2);
        send_char(8'h7E, 1'b0, 1'b1, 4, 1'b1, 1'b0, 0);

        // Abort mid-character
        put_data(8'h00, 1'b1);
        while (!io_drive_low) step(1);
        step(12);
        chk("R13 low before abort", io_drive_low, 1);
        tx_en = 1'b0;
        step(1);
        chk("R13 released after abort", io_drive_low, 0);
        chk("R9 end after abort", sts_flags[1], 1);
        tx_en = 1'b1;
        quiet_window("R3 no restart after abort", 40);

        // Random characters
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d   = 8'($urandom);
            logic       gm  = 1'($urandom);
            logic       blk = 1'($urandom);
            int         lim = 4 + int'($urandom % 6);
            bit         inj = ($urandom % 4) == 0;
            bit         dma = 1'($urandom);
            int         rec = int'($urandom % 3);
            send_char(d, gm, blk, lim, inj, dma, rec);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule